// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block models the register set of one Ethernet PHY as seen through a management read/write port. An access is a single-cycle strobe that carries a 5-bit register number, a write flag and 16-bit write data. A read answers on the next cycle together with a one-cycle valid pulse. The model keeps the control, status, advertisement, interrupt-source and interrupt-mask registers. It answers the identifier, partner-ability and expansion registers with constants. Every other register number reads as zero and discards writes.

A link-state input is passed through a parameterizable synchronizer and then edge-detected. The first settled value after reset, and every later change, is folded into the status register and latches interrupt-source bits. Autonegotiation completes as soon as it is requested. The interrupt-source register clears when it is read. A registered level interrupt is raised while any source bit is enabled by the mask.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset, control is 0x3000, advertisement is 0x01E1, the mask is 0 and the sources are 0. The settled link state is then applied once. With the link up, status reads 0x782D and the sources read 0x00C0. With the link down, status reads 0x7809 and the sources read 0x0010.
- R2: Register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001.
- R3: A write to register 0 with data bit 15 clear stores data AND 0x7980 as control. If data bit 12 is set, status bit 5 is set in the same update.
- R4: A write to register 0 with data bit 15 set restores control, status, advertisement, mask and sources to their reset values. The current link state is applied again on the following cycle.
- R5: A write to register 4 stores (data AND 0x2D7F) OR 0x0080 as advertisement.
- R6: A write to register 30 stores data bits 7:0 as the interrupt mask. Register 30 reads back with bits 15:8 as zero.
- R7: A read of register 29 returns the source bits held before the access and clears them. A link event applied in the same cycle as the read still leaves its bits set afterwards.
- R8: On a link-down event, status bits 2 and 5 clear and source bit 4 sets. On a link-up event, status bits 2 and 5 set and source bits 7 and 6 set. Events occur only on a change of the synchronized link level, so a steady link adds no new source bits.
- R9: Register 1, the constant registers, register 29 and every unlisted register number (including 17, 18, 27 and 31) ignore writes. Unlisted register numbers read as 0.
- R10: irq equals the OR of (sources AND mask) as it stood one cycle earlier.
- R11: mgmt_rvld pulses exactly one cycle after a read strobe, and mgmt_rdata is valid in that cycle. A write never produces mgmt_rvld. A register update is visible to a read strobed in the cycle after the write.
- R12: link_up passes through SYNC_STAGES flip-flops before edge detection. With the default of 2, a change presented before clock edge 1 updates the registers at edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_vld | input | 1 | Access strobe, one cycle per access |
| mgmt_wr | input | 1 | 1 = write, 0 = read |
| mgmt_reg | input | 5 | Register number |
| mgmt_wdata | input | DATA_W | Write data |
| link_up | input | 1 | Link state, 1 = up (asynchronous) |
| mgmt_rdata | output | DATA_W | Read data, valid with mgmt_rvld |
| mgmt_rvld | output | 1 | Read-data valid pulse |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit data, an 8-bit source register and a two-stage link synchronizer. The two-stage depth makes the link-to-register latency long enough to place a clear-on-read in exactly the cycle a link event lands, which exercises the rule in R7 that a new event beats the clear. It also lets the bench show that the first settled link value after reset, not the reset value of the synchronizer, is the one reported.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int REG_AW = 5;
   typedef logic [REG_AW-1:0] reg_num_t;

   // register numbers decoded by the management side
   localparam reg_num_t REG_CTRL  = 5'd0;
   localparam reg_num_t REG_STAT  = 5'd1;
   localparam reg_num_t REG_IDHI  = 5'd2;
   localparam reg_num_t REG_IDLO  = 5'd3;
   localparam reg_num_t REG_ADV   = 5'd4;
   localparam reg_num_t REG_LPA   = 5'd5;
   localparam reg_num_t REG_EXP   = 5'd6;
   localparam reg_num_t REG_ISRC  = 5'd29;
   localparam reg_num_t REG_IMASK = 5'd30;

   // control / status bit positions
   localparam int CTRL_SWRST_BIT  = 15;
   localparam int CTRL_ANSTART_BIT = 12;
   localparam int STAT_LINK_BIT   = 2;
   localparam int STAT_ANDONE_BIT = 5;

   // interrupt-source bit positions
   localparam int SRC_DOWN_BIT   = 4;
   localparam int SRC_ANDONE_BIT = 6;
   localparam int SRC_ENERGY_BIT = 7;

endpackage

// File: rtl/phy_link_edge.sv
module phy_link_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_in,
   output logic link_lvl,
   output logic link_evt
);
   localparam int CNT_W = (SYNC_STAGES < 1) ? 1 : $clog2(SYNC_STAGES + 1);
   localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(SYNC_STAGES);

   logic             link_s;
   logic             link_q;
   logic             first_q;
   logic             ready;
   logic [CNT_W-1:0] fill_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign link_s = link_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= link_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sync_q[i] <= sync_q[i-1];
               end
            end
         end
         assign link_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   // the level is trusted only once the synchronizer has filled
   assign ready = (fill_q == FILL_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q  <= '0;
         first_q <= 1'b1;
         link_q  <= 1'b0;
      end else begin
         if (!ready) begin
            fill_q <= fill_q + 1'b1;
         end else begin
            first_q <= 1'b0;
            link_q  <= link_s;
         end
      end
   end

   assign link_lvl = link_s;
   assign link_evt = ready & (first_q | (link_s ^ link_q));

endmodule

// File: rtl/phy_reg_core.sv
module phy_reg_core
   import phy_mgmt_pkg::*;
#(
   parameter int               DATA_W     = 16,
   parameter int               SRC_W      = 8,
   parameter logic [DATA_W-1:0] CTRL_RST   = 16'h3000,
   parameter logic [DATA_W-1:0] STAT_RST   = 16'h7809,
   parameter logic [DATA_W-1:0] ADV_RST    = 16'h01E1,
   parameter logic [DATA_W-1:0] CTRL_WMASK = 16'h7980,
   parameter logic [DATA_W-1:0] ADV_WMASK  = 16'h2D7F,
   parameter logic [DATA_W-1:0] ADV_FORCE  = 16'h0080,
   parameter logic [DATA_W-1:0] ID_HI_VAL  = 16'h0007,
   parameter logic [DATA_W-1:0] ID_LO_VAL  = 16'hC0D1,
   parameter logic [DATA_W-1:0] LPA_VAL    = 16'h0F71,
   parameter logic [DATA_W-1:0] EXP_VAL    = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic              acc_wr,
   input  reg_num_t          acc_num,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              link_lvl,
   input  logic              link_evt,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic [DATA_W-1:0] ctrl,
   output logic [DATA_W-1:0] stat,
   output logic [DATA_W-1:0] adv,
   output logic [SRC_W-1:0]  isrc,
   output logic [SRC_W-1:0]  imask,
   output logic              soft_apply
);
   localparam logic [DATA_W-1:0] STAT_LINK_MASK =
      (DATA_W'(1) << STAT_LINK_BIT) | (DATA_W'(1) << STAT_ANDONE_BIT);

   logic [DATA_W-1:0] ctrl_q, stat_q, adv_q, ctrl_n, stat_n, adv_n;
   logic [SRC_W-1:0]  src_q, mask_q, src_n, mask_n;
   logic              soft_q, soft_n;
   logic [DATA_W-1:0] rd_q, rd_mux;
   logic              rvld_q;

   always_comb begin
      ctrl_n = ctrl_q;
      stat_n = stat_q;
      adv_n  = adv_q;
      src_n  = src_q;
      mask_n = mask_q;
      soft_n = 1'b0;
      if (acc_vld) begin
         if (acc_wr) begin
            case (acc_num)
               REG_CTRL: begin
                  if (acc_wdata[CTRL_SWRST_BIT]) begin
                     ctrl_n = CTRL_RST;
                     stat_n = STAT_RST;
                     adv_n  = ADV_RST;
                     src_n  = '0;
                     mask_n = '0;
                     soft_n = 1'b1;
                  end else begin
                     ctrl_n = acc_wdata & CTRL_WMASK;
                     if (acc_wdata[CTRL_ANSTART_BIT]) begin
                        stat_n[STAT_ANDONE_BIT] = 1'b1;
                     end
                  end
               end
               REG_ADV:   adv_n  = (acc_wdata & ADV_WMASK) | ADV_FORCE;
               REG_IMASK: mask_n = acc_wdata[SRC_W-1:0];
               default: ;
            endcase
         end else if (acc_num == REG_ISRC) begin
            src_n = '0;
         end
      end
      // link state is folded in after the access so new events survive a clear
      if ((link_evt | soft_q) & !soft_n) begin
         if (link_lvl) begin
            stat_n                = stat_n | STAT_LINK_MASK;
            src_n[SRC_ENERGY_BIT] = 1'b1;
            src_n[SRC_ANDONE_BIT] = 1'b1;
         end else begin
            stat_n              = stat_n & ~STAT_LINK_MASK;
            src_n[SRC_DOWN_BIT] = 1'b1;
         end
      end
   end

   always_comb begin
      case (acc_num)
         REG_CTRL:  rd_mux = ctrl_q;
         REG_STAT:  rd_mux = stat_q;
         REG_IDHI:  rd_mux = ID_HI_VAL;
         REG_IDLO:  rd_mux = ID_LO_VAL;
         REG_ADV:   rd_mux = adv_q;
         REG_LPA:   rd_mux = LPA_VAL;
         REG_EXP:   rd_mux = EXP_VAL;
         REG_ISRC:  rd_mux = DATA_W'(src_q);
         REG_IMASK: rd_mux = DATA_W'(mask_q);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         stat_q <= STAT_RST;
         adv_q  <= ADV_RST;
         src_q  <= '0;
         mask_q <= '0;
         soft_q <= 1'b0;
         rd_q   <= '0;
         rvld_q <= 1'b0;
      end else begin
         ctrl_q <= ctrl_n;
         stat_q <= stat_n;
         adv_q  <= adv_n;
         src_q  <= src_n;
         mask_q <= mask_n;
         soft_q <= soft_n;
         rvld_q <= acc_vld & !acc_wr;
         if (acc_vld & !acc_wr) begin
            rd_q <= rd_mux;
         end
      end
   end

   assign rd_data    = rd_q;
   assign rd_vld     = rvld_q;
   assign ctrl       = ctrl_q;
   assign stat       = stat_q;
   assign adv        = adv_q;
   assign isrc       = src_q;
   assign imask      = mask_q;
   assign soft_apply = soft_q;

endmodule

// File: rtl/phy_irq_out.sv
module phy_irq_out #(
   parameter int SRC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src,
   input  logic [SRC_W-1:0] mask,
   output logic             irq
);
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(src & mask);
   end

   assign irq = irq_q;

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SRC_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mgmt_vld,
   input  logic              mgmt_wr,
   input  logic [4:0]        mgmt_reg,
   input  logic [DATA_W-1:0] mgmt_wdata,
   input  logic              link_up,
   output logic [DATA_W-1:0] mgmt_rdata,
   output logic              mgmt_rvld,
   output logic              irq
);
   generate
      if (DATA_W < 16) begin : g_bad_data_w
         $error("DATA_W must be at least 16");
      end
      if (SRC_W < 8 || SRC_W > DATA_W) begin : g_bad_src_w
         $error("SRC_W must lie between 8 and DATA_W");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              link_lvl, link_evt, soft_apply;
   logic [DATA_W-1:0] ctrl_w, stat_w, adv_w;
   logic [SRC_W-1:0]  isrc_w, imask_w;

   phy_link_edge #(.SYNC_STAGES(SYNC_STAGES)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .link_in  (link_up),
      .link_lvl (link_lvl),
      .link_evt (link_evt)
   );

   phy_reg_core #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_vld    (mgmt_vld),
      .acc_wr     (mgmt_wr),
      .acc_num    (mgmt_reg),
      .acc_wdata  (mgmt_wdata),
      .link_lvl   (link_lvl),
      .link_evt   (link_evt),
      .rd_data    (mgmt_rdata),
      .rd_vld     (mgmt_rvld),
      .ctrl       (ctrl_w),
      .stat       (stat_w),
      .adv        (adv_w),
      .isrc       (isrc_w),
      .imask      (imask_w),
      .soft_apply (soft_apply)
   );

   phy_irq_out #(.SRC_W(SRC_W)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (isrc_w),
      .mask  (imask_w),
      .irq   (irq)
   );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
   parameter int DATA_W = 16,
   parameter int SRC_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mgmt_vld,
   input logic              mgmt_wr,
   input logic [4:0]        mgmt_reg,
   input logic [DATA_W-1:0] mgmt_wdata,
   input logic              mgmt_rvld,
   input logic              irq,
   input logic [DATA_W-1:0] ctrl,
   input logic [DATA_W-1:0] stat,
   input logic [DATA_W-1:0] adv,
   input logic [SRC_W-1:0]  isrc,
   input logic [SRC_W-1:0]  imask,
   input logic              link_lvl,
   input logic              link_evt,
   input logic              soft_apply
);
   logic rd_acc, wr_ctrl, swrst;
   assign rd_acc  = mgmt_vld && !mgmt_wr;
   assign wr_ctrl = mgmt_vld && mgmt_wr && (mgmt_reg == 5'd0);
   assign swrst   = wr_ctrl && mgmt_wdata[15];

   AST_RVLD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> mgmt_rvld); // R11
   AST_NO_RVLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_acc |=> !mgmt_rvld); // R11
   AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !mgmt_wdata[15]) |=> ctrl == ($past(mgmt_wdata) & DATA_W'(16'h7980))); // R3
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      swrst |=> (ctrl == DATA_W'(16'h3000)) && (adv == DATA_W'(16'h01E1)) && (imask == '0) && soft_apply); // R4
   AST_ADV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_vld && mgmt_wr && mgmt_reg == 5'd4)
      |=> adv == (($past(mgmt_wdata) & DATA_W'(16'h2D7F)) | DATA_W'(16'h0080))); // R5
   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_vld && mgmt_wr && mgmt_reg == 5'd30) |=> imask == $past(mgmt_wdata[SRC_W-1:0])); // R6
   AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && mgmt_reg == 5'd29 && !link_evt && !soft_apply) |=> isrc == '0); // R7
   AST_LINK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (link_evt && !link_lvl && !swrst) |=> !stat[2] && !stat[5] && isrc[4]); // R8
   AST_LINK_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (link_evt && link_lvl && !swrst) |=> stat[2] && stat[5] && isrc[7] && isrc[6]); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mgmt_vld && !link_evt && !soft_apply)
      |=> $stable(ctrl) && $stable(stat) && $stable(adv) && $stable(isrc) && $stable(imask)); // R9
   AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq == $past(|(isrc & imask))); // R10

endmodule

bind phy_mgmt_regs phy_mgmt_chk #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mgmt_vld   (mgmt_vld),
   .mgmt_wr    (mgmt_wr),
   .mgmt_reg   (mgmt_reg),
   .mgmt_wdata (mgmt_wdata),
   .mgmt_rvld  (mgmt_rvld),
   .irq        (irq),
   .ctrl       (ctrl_w),
   .stat       (stat_w),
   .adv        (adv_w),
   .isrc       (isrc_w),
   .imask      (imask_w),
   .link_lvl   (link_lvl),
   .link_evt   (link_evt),
   .soft_apply (soft_apply)
);

// File: tb/sim_phy_mgmt_regs.sv
`timescale 1ns/1ps
module sim_phy_mgmt_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mgmt_vld = 1'b0;
   logic        mgmt_wr = 1'b0;
   logic [4:0]  mgmt_reg = '0;
   logic [15:0] mgmt_wdata = '0;
   logic        link_up = 1'b1;
   logic [15:0] mgmt_rdata;
   logic        mgmt_rvld;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   phy_mgmt_regs #(.DATA_W(16), .SRC_W(8), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .mgmt_vld(mgmt_vld), .mgmt_wr(mgmt_wr),
      .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata), .link_up(link_up),
      .mgmt_rdata(mgmt_rdata), .mgmt_rvld(mgmt_rvld), .irq(irq)
   );

   // {wr, reg, wdata, expected read, requirement number}
   typedef logic [41:0] vec_t;
   localparam int NVEC = 30;
   localparam vec_t VEC [NVEC] = '{
      {1'b0, 5'd0,  16'h0000, 16'h3000, 4'd1},   // R1 control reset
      {1'b0, 5'd1,  16'h0000, 16'h782D, 4'd1},   // R1 status with link up
      {1'b0, 5'd2,  16'h0000, 16'h0007, 4'd2},   // R2
      {1'b0, 5'd3,  16'h0000, 16'hC0D1, 4'd2},   // R2
      {1'b0, 5'd4,  16'h0000, 16'h01E1, 4'd1},   // R1 advertisement reset
      {1'b0, 5'd5,  16'h0000, 16'h0F71, 4'd2},   // R2
      {1'b0, 5'd6,  16'h0000, 16'h0001, 4'd2},   // R2
      {1'b0, 5'd30, 16'h0000, 16'h0000, 4'd1},   // R1 mask reset
      {1'b0, 5'd29, 16'h0000, 16'h00C0, 4'd1},   // R1 link-up sources
      {1'b0, 5'd29, 16'h0000, 16'h0000, 4'd7},   // R7 cleared by the read
      {1'b1, 5'd4,  16'hFFFF, 16'h0000, 4'd5},
      {1'b0, 5'd4,  16'h0000, 16'h2DFF, 4'd5},   // R5
      {1'b1, 5'd4,  16'h0000, 16'h0000, 4'd5},
      {1'b0, 5'd4,  16'h0000, 16'h0080, 4'd5},   // R5 forced bit
      {1'b1, 5'd0,  16'h7FFF, 16'h0000, 4'd3},
      {1'b0, 5'd0,  16'h0000, 16'h7980, 4'd3},   // R3
      {1'b1, 5'd30, 16'hABCD, 16'h0000, 4'd6},
      {1'b0, 5'd30, 16'h0000, 16'h00CD, 4'd6},   // R6
      {1'b1, 5'd1,  16'h0000, 16'h0000, 4'd9},
      {1'b0, 5'd1,  16'h0000, 16'h782D, 4'd9},   // R9 status read-only
      {1'b1, 5'd2,  16'h1234, 16'h0000, 4'd9},
      {1'b0, 5'd2,  16'h0000, 16'h0007, 4'd9},   // R9 constant untouched
      {1'b1, 5'd17, 16'hFFFF, 16'h0000, 4'd9},
      {1'b0, 5'd17, 16'h0000, 16'h0000, 4'd9},   // R9
      {1'b0, 5'd18, 16'h0000, 16'h0000, 4'd9},   // R9
      {1'b0, 5'd27, 16'h0000, 16'h0000, 4'd9},   // R9
      {1'b0, 5'd31, 16'h0000, 16'h0000, 4'd9},   // R9
      {1'b0, 5'd9,  16'h0000, 16'h0000, 4'd9},   // R9
      {1'b1, 5'd29, 16'hFFFF, 16'h0000, 4'd9},
      {1'b0, 5'd29, 16'h0000, 16'h0000, 4'd9}    // R9 sources not writable
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [4:0] num, input logic [15:0] d,
                         output logic [15:0] rd, output logic rv);
      @(negedge clk);
      mgmt_vld   = 1'b1;
      mgmt_wr    = wr;
      mgmt_reg   = num;
      mgmt_wdata = d;
      @(negedge clk);
      mgmt_vld   = 1'b0;
      mgmt_wr    = 1'b0;
      rd = mgmt_rdata;
      rv = mgmt_rvld;
   endtask

   task automatic rd_check(input string req, input logic [4:0] num, input logic [15:0] exp);
      logic [15:0] rd;
      logic        rv;
      access(1'b0, num, 16'h0, rd, rv);
      check(req, {15'd0, rv, rd}, {15'd0, 1'b1, exp});
   endtask

   task automatic wr_do(input logic [4:0] num, input logic [15:0] d);
      logic [15:0] rd;
      logic        rv;
      access(1'b1, num, d, rd, rv);
      check("R11 no valid on write", {31'd0, rv}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      logic        rv;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq low after reset", {31'd0, irq}, 32'd0);
      check("R11 no valid after reset", {31'd0, mgmt_rvld}, 32'd0);
      repeat (8) @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         access(VEC[i][41], VEC[i][40:36], VEC[i][35:20], rd, rv);
         if (!VEC[i][41]) begin
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), {16'd0, rd}, {16'd0, VEC[i][19:4]});
         end
         check($sformatf("R11 valid vector %0d", i), {31'd0, rv}, {31'd0, !VEC[i][41]});
      end

      // R10: mask 0xCD, no sources
      check("R10 irq idle", {31'd0, irq}, 32'd0);
      link_up = 1'b0;
      repeat (8) @(negedge clk);
      rd_check("R8 status after link down", 5'd1, 16'h7809);
      check("R10 masked source keeps irq low", {31'd0, irq}, 32'd0);
      wr_do(5'd30, 16'h0010);
      check("R10 irq one cycle late", {31'd0, irq}, 32'd0);
      @(negedge clk);
      check("R10 irq raised", {31'd0, irq}, 32'd1);
      rd_check("R7 read returns down bit", 5'd29, 16'h0010);
      check("R10 irq still high in clear cycle", {31'd0, irq}, 32'd1);
      @(negedge clk);
      check("R10 irq drops after clear", {31'd0, irq}, 32'd0);

      link_up = 1'b1;
      repeat (8) @(negedge clk);
      rd_check("R8 link-up sources", 5'd29, 16'h00C0);
      rd_check("R8 status after link up", 5'd1, 16'h782D);
      repeat (10) @(negedge clk);
      rd_check("R8 steady link adds nothing", 5'd29, 16'h0000);

      // link drop lands at the third edge, together with a clearing read
      @(negedge clk);
      link_up = 1'b0;
      @(negedge clk);
      rd_check("R12 event not yet applied", 5'd29, 16'h0000);
      rd_check("R7 event survives same-cycle clear", 5'd29, 16'h0010);

      wr_do(5'd0, 16'h1000);
      rd_check("R3 autoneg done at once", 5'd1, 16'h7829);
      rd_check("R3 control masked", 5'd0, 16'h1000);

      wr_do(5'd30, 16'h00FF);
      wr_do(5'd4, 16'h0000);
      wr_do(5'd0, 16'h8000);
      rd_check("R4 control restored", 5'd0, 16'h3000);
      rd_check("R4 advertisement restored", 5'd4, 16'h01E1);
      rd_check("R4 mask cleared", 5'd30, 16'h0000);
      rd_check("R4 link reapplied", 5'd29, 16'h0010);
      rd_check("R4 status restored", 5'd1, 16'h7809);

      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);
      check("R1 irq low after reset, link down", {31'd0, irq}, 32'd0);
      rd_check("R1 status reset, link down", 5'd1, 16'h7809);
      rd_check("R1 sources reset, link down", 5'd29, 16'h0010);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule